// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block keeps the delivery state of inter-processor software interrupts with IDs 0 to 15 in a multi-processor system. A processor raises such an interrupt by issuing a dispatch command. The command carries the interrupt ID and a filter field that picks the destination processors. For every pair of interrupt and destination, the block keeps a pending flag and a bitmap of the processors that sent that interrupt. Several senders can therefore be outstanding on one pair at the same time.

A destination processor services the interrupt by issuing an acknowledge command for an ID. The block returns the lowest-numbered outstanding sender, encoded above the ID, and removes only that sender from the bitmap. The pending flag stays set until the last sender has been handed out. Two byte-wide commands let a processor add sender bits to, or remove sender bits from, its own slot for an ID.

All requests share one command port and are tagged with the requester's processor number. The pending flags are exported as a flat vector for the priority logic downstream.

Top module: `sgi_dispatch`

## Requirements
- R1: While `rst` is high at a clock edge, every pending flag and every sender bitmap is cleared, and `rsp_valid` is low after that edge.
- R2: Commands use `cmd_op` 0 = dispatch, 1 = add-senders, 2 = remove-senders, 3 = acknowledge. A dispatch takes the ID from `cmd_data[9:0]` and the filter from `cmd_data[25:24]`. A dispatch whose ID is 16 or more changes no state.
- R3: Filter 0 takes the destination list from `cmd_data[23:16]`, bit n meaning processor n. List bits at or above NUM_CPU are ignored.
- R4: Filter 1 targets every processor except the requester, filter 2 targets only the requester, and filter 3 targets all processors.
- R5: For each destination of a dispatch, the pending flag of the ID is set and the requester's bit is OR-ed into that destination's sender bitmap. The flags appear on `pend_o` (bit `cpu*16 + id`) after the clock edge that takes the command.
- R6: An acknowledge names the ID in `cmd_data[9:0]` and the requester as the servicing processor. On the next edge `rsp_valid` is high for one cycle and `rsp_data` = ID + (lowest set sender number << 10), with bits [31:13] and [9:4] zero. That sender's bit is cleared. Every other command leaves `rsp_valid` low.
- R7: A pending flag stays set while its sender bitmap is non-empty. An acknowledge that removes the last sender clears it.
- R8: An acknowledge whose bitmap is empty, or whose ID is 16 or more, returns 1023 and changes no state, including a pending flag that is set with no sender.
- R9: Remove-senders (ID in `cmd_data[11:8]`, mask in `cmd_data[7:0]`) clears the masked bits of the requester's bitmap for that ID. It clears the pending flag only when the bitmap becomes empty.
- R10: Add-senders (same fields) ORs the mask into the requester's bitmap for that ID and sets that pending flag, even when the mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | Command code (R2) |
| cmd_cpu | input | CPU_W | Requesting processor number |
| cmd_data | input | 32 | Command word |
| rsp_valid | output | 1 | Acknowledge result valid |
| rsp_data | output | 32 | Acknowledge result word |
| pend_o | output | NUM_CPU*16 | Pending flags, bit cpu*16+id |

## Verification
Dispatches are driven with each of the four filters, with destination lists that carry bits beyond the processor count, and with IDs outside the valid range. Together these separate the filter decoding from the per-slot update. Several senders are stacked on one slot and then drained by repeated acknowledges, which shows the lowest-first order and the hold-until-empty pending rule. Add- and remove-senders commands with partial and zero masks tell the sender-bit path apart from the pending-flag path. An acknowledge on an empty slot that has its pending flag set shows that the error response leaves all state alone.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int SGI_COUNT   = 16;
    localparam int MAX_CPU     = 8;
    localparam int ID_W        = 10;
    localparam int SRC_LSB     = 10;
    localparam int SPURIOUS_ID = 1023;

    typedef enum logic [1:0] {
        OP_DISPATCH = 2'd0,
        OP_SRC_SET  = 2'd1,
        OP_SRC_CLR  = 2'd2,
        OP_ACK      = 2'd3
    } sgi_op_e;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_ALL    = 2'd3
    } sgi_filter_e;

    // One cycle's update request for one (interrupt, destination) slot.
    typedef struct packed {
        logic [MAX_CPU-1:0] or_bits;
        logic [MAX_CPU-1:0] andn_bits;
        logic               force_pend;
        logic               chk_empty;
    } slot_upd_t;

    function automatic logic [2:0] lowest_set(input logic [MAX_CPU-1:0] v);
        logic [2:0] idx;
        idx = 3'd0;
        for (int i = MAX_CPU - 1; i >= 0; i--) begin
            if (v[i]) idx = 3'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  sgi_filter_e            filter,
    input  logic [MAX_CPU-1:0]     list,
    input  logic [CPU_W-1:0]       writer,
    output logic [NUM_CPU-1:0]     targets
);
    logic [NUM_CPU-1:0] self_mask;
    logic [NUM_CPU-1:0] all_mask;

    always_comb begin
        self_mask = NUM_CPU'(1) << writer;
        all_mask  = '1;
        unique case (filter)
            FLT_LIST:   targets = list[NUM_CPU-1:0];
            FLT_OTHERS: targets = all_mask & ~self_mask;
            FLT_SELF:   targets = self_mask;
            default:    targets = all_mask;
        endcase
    end
endmodule

// File: rtl/sgi_slot.sv
module sgi_slot
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  slot_upd_t          upd,
    output logic [NUM_CPU-1:0] senders,
    output logic               pending
);
    logic [NUM_CPU-1:0] bm_q;
    logic [NUM_CPU-1:0] bm_nxt;
    logic               pend_q;

    assign bm_nxt = (bm_q | upd.or_bits[NUM_CPU-1:0]) & ~upd.andn_bits[NUM_CPU-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bm_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            bm_q <= bm_nxt;
            if (upd.force_pend)
                pend_q <= 1'b1;
            else if (upd.chk_empty && (bm_nxt == '0))
                pend_q <= 1'b0;
        end
    end

    assign senders = bm_q;
    assign pending = pend_q;
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int PEND_W = NUM_CPU * SGI_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CPU_W-1:0]  cmd_cpu,
    input  logic [31:0]       cmd_data,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic [PEND_W-1:0] pend_o
);
    sgi_op_e            op;
    logic               writer_ok;
    logic [ID_W-1:0]    cmd_id;
    logic               id_ok;
    logic [3:0]         src_id;
    logic [MAX_CPU-1:0] src_mask;
    logic [MAX_CPU-1:0] writer_bit;
    logic [NUM_CPU-1:0] targets;
    logic               is_disp, is_set, is_clr, is_ack;
    logic [NUM_CPU-1:0] bm_all [SGI_COUNT][NUM_CPU];
    logic [NUM_CPU-1:0] ack_bm;
    logic               ack_hit;
    logic [2:0]         ack_src;
    logic               unused_bits;

    assign op         = sgi_op_e'(cmd_op);
    assign writer_ok  = (32'(cmd_cpu) < NUM_CPU);
    assign cmd_id     = cmd_data[ID_W-1:0];
    assign id_ok      = (cmd_id < ID_W'(SGI_COUNT));
    assign src_id     = cmd_data[11:8];
    assign src_mask   = cmd_data[7:0];
    assign writer_bit = MAX_CPU'(1) << cmd_cpu;
    assign unused_bits = ^{cmd_data[31:26], cmd_data[15:12]};

    assign is_disp = cmd_valid && writer_ok && (op == OP_DISPATCH) && id_ok;
    assign is_set  = cmd_valid && writer_ok && (op == OP_SRC_SET);
    assign is_clr  = cmd_valid && writer_ok && (op == OP_SRC_CLR);
    assign is_ack  = cmd_valid && (op == OP_ACK);

    sgi_target_decode #(.NUM_CPU(NUM_CPU)) u_tgt (
        .filter  (sgi_filter_e'(cmd_data[25:24])),
        .list    (cmd_data[23:16]),
        .writer  (cmd_cpu),
        .targets (targets)
    );

    // Acknowledge lookup: the requester's bitmap for the named ID.
    always_comb begin
        ack_bm = '0;
        if (writer_ok && id_ok) ack_bm = bm_all[cmd_id[3:0]][cmd_cpu];
        ack_hit = is_ack && (ack_bm != '0);
        ack_src = lowest_set(MAX_CPU'(ack_bm));
    end

    for (genvar s = 0; s < SGI_COUNT; s++) begin : g_sgi
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            slot_upd_t upd;
            logic      pend_bit;
            logic      own;

            assign own = (cmd_cpu == CPU_W'(c));

            always_comb begin
                upd = '0;
                if (is_disp && (cmd_id[3:0] == 4'(s)) && targets[c]) begin
                    upd.or_bits    = writer_bit;
                    upd.force_pend = 1'b1;
                end
                if (is_set && own && (src_id == 4'(s))) begin
                    upd.or_bits    = src_mask;
                    upd.force_pend = 1'b1;
                end
                if (is_clr && own && (src_id == 4'(s))) begin
                    upd.andn_bits  = src_mask;
                    upd.chk_empty  = 1'b1;
                end
                if (ack_hit && own && (cmd_id[3:0] == 4'(s))) begin
                    upd.andn_bits  = MAX_CPU'(1) << ack_src;
                    upd.chk_empty  = 1'b1;
                end
            end

            sgi_slot #(.NUM_CPU(NUM_CPU)) u_slot (
                .clk     (clk),
                .rst     (rst),
                .upd     (upd),
                .senders (bm_all[s][c]),
                .pending (pend_bit)
            );

            assign pend_o[c*SGI_COUNT + s] = pend_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= is_ack;
            if (is_ack) begin
                if (ack_hit)
                    rsp_data <= 32'(cmd_id) | (32'(ack_src) << SRC_LSB);
                else
                    rsp_data <= 32'(SPURIOUS_ID);
            end
        end
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int PEND_W = NUM_CPU * SGI_COUNT
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [CPU_W-1:0]  cmd_cpu,
    input logic [31:0]       cmd_data,
    input logic              rsp_valid,
    input logic [31:0]       rsp_data,
    input logic [PEND_W-1:0] pend_o
);
    logic is_ack_cmd;
    logic can_clear;
    logic can_set;
    assign is_ack_cmd = cmd_valid && (cmd_op == 2'(OP_ACK));
    assign can_clear  = cmd_valid && ((cmd_op == 2'(OP_ACK)) || (cmd_op == 2'(OP_SRC_CLR)));
    assign can_set    = cmd_valid && ((cmd_op == 2'(OP_DISPATCH)) || (cmd_op == 2'(OP_SRC_SET)));

    // R1
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pend_o == '0) && !rsp_valid);

    // R6: a response follows exactly the acknowledge commands
    assert_rsp_follows_ack_R6: assert property (@(posedge clk) disable iff (rst)
        is_ack_cmd |=> rsp_valid);
    assert_no_rsp_otherwise_R6: assert property (@(posedge clk) disable iff (rst)
        !is_ack_cmd |=> !rsp_valid);
    assert_rsp_format_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_data != 32'(SPURIOUS_ID)) |->
            (rsp_data[31:13] == '0) && (rsp_data[9:4] == '0) &&
            (32'(rsp_data[12:10]) < NUM_CPU));

    // R8: an error acknowledge leaves every pending flag alone
    assert_err_ack_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_data == 32'(SPURIOUS_ID)) |-> $stable(pend_o));

    // R7 / R9: flags fall only after a remove-senders or acknowledge
    assert_pend_fall_cause_R7: assert property (@(posedge clk) disable iff (rst)
        can_clear || !can_clear |=> ((|($past(pend_o) & ~pend_o)) -> $past(can_clear)));

    // R5 / R10: flags rise only after a dispatch or add-senders
    assert_pend_rise_cause_R5: assert property (@(posedge clk) disable iff (rst)
        can_set || !can_set |=> ((|(~$past(pend_o) & pend_o)) -> $past(can_set)));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_cpu   (cmd_cpu),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .pend_o    (pend_o)
);

// File: tb/sgi_dispatch_tb.sv
`timescale 1ns/1ps
module sgi_dispatch_tb;
    localparam int NCPU = 4;
    localparam int PW   = NCPU * 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid;
    logic [1:0]    cmd_op;
    logic [1:0]    cmd_cpu;
    logic [31:0]   cmd_data;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic [PW-1:0] pend_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sgi_dispatch #(.NUM_CPU(NCPU)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cpu(cmd_cpu), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .pend_o(pend_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one command at a falling edge; outputs are sampled at the next one.
    task automatic cmd(input logic [1:0] op, input logic [1:0] cpu, input logic [31:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_cpu = cpu; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_data = '0;
    endtask

    function automatic logic [31:0] disp_word(input logic [1:0] flt, input logic [7:0] list,
                                              input logic [9:0] id);
        return {6'b0, flt, list, 6'b0, id};
    endfunction

    function automatic logic [63:0] pbit(input int cpu, input int id);
        return 64'(1) << (cpu * 16 + id);
    endfunction

    task automatic dispatch(input logic [1:0] cpu, input logic [1:0] flt,
                            input logic [7:0] list, input logic [9:0] id);
        cmd(2'd0, cpu, disp_word(flt, list, id));
        check(!rsp_valid, "R6 no response to dispatch", 64'(rsp_valid), 0);
    endtask

    task automatic ack_expect(input logic [1:0] cpu, input logic [9:0] id,
                              input logic [31:0] exp, input string req);
        cmd(2'd3, cpu, {22'b0, id});
        check(rsp_valid == 1'b1, req, 64'(rsp_valid), 1);
        check(rsp_data == exp, req, 64'(rsp_data), 64'(exp));
    endtask

    task automatic expect_pend(input logic [63:0] exp, input string req);
        check(64'(pend_o) == exp, req, 64'(pend_o), exp);
    endtask

    task automatic t_reset;
        expect_pend(0, "R1 pending clear after reset");
        check(!rsp_valid, "R1 rsp_valid low after reset", 64'(rsp_valid), 0);
    endtask

    task automatic t_self_filter;
        dispatch(2'd1, 2'd2, 8'h00, 10'd5);
        expect_pend(pbit(1, 5), "R4 filter 2 targets writer only");
        ack_expect(2'd1, 10'd5, 32'd5 | (32'd1 << 10), "R6 ack returns id and source");
        expect_pend(0, "R7 pending cleared when last sender taken");
    endtask

    task automatic t_multi_sender;
        dispatch(2'd0, 2'd0, 8'h02, 10'd7);
        dispatch(2'd3, 2'd0, 8'h02, 10'd7);
        dispatch(2'd2, 2'd0, 8'h02, 10'd7);
        expect_pend(pbit(1, 7), "R5 list filter sets destination pending");
        ack_expect(2'd1, 10'd7, 32'd7, "R6 lowest sender first");
        expect_pend(pbit(1, 7), "R7 pending held with senders left");
        ack_expect(2'd1, 10'd7, 32'd7 | (32'd2 << 10), "R6 second sender");
        expect_pend(pbit(1, 7), "R7 pending held with one sender left");
        ack_expect(2'd1, 10'd7, 32'd7 | (32'd3 << 10), "R6 third sender");
        expect_pend(0, "R7 pending cleared at empty");
        ack_expect(2'd1, 10'd7, 32'd1023, "R8 ack on empty slot");
    endtask

    task automatic t_others_filter;
        dispatch(2'd2, 2'd1, 8'h00, 10'd3);
        expect_pend(pbit(0, 3) | pbit(1, 3) | pbit(3, 3), "R4 filter 1 excludes writer");
        for (int c = 0; c < NCPU; c++) begin
            if (c != 2) ack_expect(2'(c), 10'd3, 32'd3 | (32'd2 << 10), "R6 filter 1 ack");
        end
        expect_pend(0, "R7 filter 1 drained");
    endtask

    task automatic t_all_filter;
        dispatch(2'd0, 2'd3, 8'h00, 10'd15);
        expect_pend(pbit(0, 15) | pbit(1, 15) | pbit(2, 15) | pbit(3, 15),
                    "R4 filter 3 targets all");
        for (int c = 0; c < NCPU; c++) ack_expect(2'(c), 10'd15, 32'd15, "R6 filter 3 ack");
        expect_pend(0, "R7 filter 3 drained");
    endtask

    task automatic t_list_mask;
        dispatch(2'd3, 2'd0, 8'hF1, 10'd0);
        expect_pend(pbit(0, 0), "R3 list bits above processor count ignored");
        ack_expect(2'd0, 10'd0, 32'd0 | (32'd3 << 10), "R3 list ack");
        expect_pend(0, "R3 drained");
    endtask

    task automatic t_bad_id;
        dispatch(2'd1, 2'd3, 8'h00, 10'd16);
        expect_pend(0, "R2 dispatch id 16 ignored");
        dispatch(2'd1, 2'd3, 8'h00, 10'd1023);
        expect_pend(0, "R2 dispatch id 1023 ignored");
        ack_expect(2'd1, 10'd20, 32'd1023, "R8 ack id out of range");
    endtask

    task automatic t_set_source;
        cmd(2'd1, 2'd2, {20'b0, 4'd9, 8'h05});
        expect_pend(pbit(2, 9), "R10 add-senders sets own pending");
        ack_expect(2'd2, 10'd9, 32'd9, "R10 added sender 0 first");
        ack_expect(2'd2, 10'd9, 32'd9 | (32'd2 << 10), "R10 added sender 2");
        expect_pend(0, "R7 drained after added senders");
        cmd(2'd1, 2'd1, {20'b0, 4'd4, 8'h00});
        expect_pend(pbit(1, 4), "R10 zero mask still sets pending");
        ack_expect(2'd1, 10'd4, 32'd1023, "R8 pending with no sender");
        expect_pend(pbit(1, 4), "R8 error ack keeps pending");
        cmd(2'd2, 2'd1, {20'b0, 4'd4, 8'h00});
        expect_pend(0, "R9 remove on empty bitmap clears pending");
    endtask

    task automatic t_clr_source;
        cmd(2'd1, 2'd3, {20'b0, 4'd2, 8'h0B});
        cmd(2'd2, 2'd3, {20'b0, 4'd2, 8'h02});
        expect_pend(pbit(3, 2), "R9 partial remove keeps pending");
        ack_expect(2'd3, 10'd2, 32'd2, "R9 sender 0 survives");
        ack_expect(2'd3, 10'd2, 32'd2 | (32'd3 << 10), "R9 sender 1 was removed");
        expect_pend(0, "R9 drained");
        cmd(2'd1, 2'd0, {20'b0, 4'd6, 8'h06});
        cmd(2'd2, 2'd0, {20'b0, 4'd6, 8'h06});
        expect_pend(0, "R9 full remove clears pending");
        ack_expect(2'd0, 10'd6, 32'd1023, "R9 bitmap empty after full remove");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_cpu = '0; cmd_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_self_filter();
        t_multi_sender();
        t_others_filter();
        t_all_filter();
        t_list_mask();
        t_bad_id();
        t_set_source();
        t_clr_source();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule